// File: doc/BRIEF.md
# Serial Configuration Register with Framed Readback

This block holds a 12-bit control word that is loaded one bit at a time over a dedicated serial link. A load begins when the session strobe pulses while the conversion-control input is low. Bits are then clocked in on the falling edge of the configuration clock, most significant bit first. The stored word changes only once all twelve bits have arrived. If a load is cut short, it leaves the previous word in place.

Once a load has finished, a readback clock shifts a fixed frame out of the serial output. The frame holds the stored word, then a 4-bit revision code, then a signature field. The signature field is mostly zeros and ends in a known non-zero tail. Its length depends on the format bit of the stored word. The frame is sent twice. After that, the output passes through the daisy-chain input, so that several devices can be read through one line. A rising edge on the conversion-control input ends configuration and returns the block to normal operation.

The configuration clock, readback clock, session strobe and conversion control are sampled by the block clock. The block detects their edges in that clock domain, so each of these inputs must stay at a level for at least one block-clock cycle.

Top module: `serial_cfg_reg`

## Requirements
- R1: After reset, the stored word is 12'h000, the normal-operation flag is 1 and the serial output is 0.
- R2: A rising edge on the session strobe while conversion control is low starts a load session and clears the normal-operation flag. The same edge while conversion control is high has no effect.
- R3: During a session, each falling edge of the configuration clock captures one data bit, most significant bit first. The stored word is updated in one step when the twelfth bit arrives. Bits clocked in after that, within the same session, do not change the word.
- R4: A session that is restarted, or ended by conversion control, before twelve bits have arrived leaves the stored word unchanged.
- R5: After a complete load, each rising edge of the readback clock puts one frame bit on the output. The first 16 bits are the stored word (bit 11 first) followed by the revision code (default 4'h1, bit 3 first).
- R6: With bit 8 of the stored word at 0, one frame copy is 256 bits. After the 16 header bits come 184 zeros and then 56'h30F066012480F6, most significant bit first.
- R7: With bit 8 of the stored word at 1, one frame copy is 320 bits. After the 16 header bits come 232 zeros and then 72'h30F066012480F69055, most significant bit first.
- R8: The frame is sent exactly twice. On every later readback edge, the output takes the value of the daisy-chain input sampled at that edge.
- R9: A rising edge on conversion control during configuration sets the normal-operation flag. In normal operation, edges on the readback and configuration clocks leave the output at 0 and the stored word unchanged.
- R10: Readback edges that occur during a session, before its load has completed, leave the output at 0. They also do not advance the frame, so readback after the load starts at bit 11 of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples all serial inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| convIn | input | 1 | Conversion control; low enables session start, rising edge returns to normal operation |
| rstStrobe | input | 1 | Session strobe; rising edge starts a load session |
| cfgDin | input | 1 | Serial configuration data |
| cfgClk | input | 1 | Configuration clock; data captured on its falling edge |
| rdClk | input | 1 | Readback clock; one output bit per rising edge |
| chainIn | input | 1 | Serial data from the next device in the chain |
| dout | output | 1 | Serial readback output |
| cfgWord | output | 12 | Stored configuration word |
| normalMode | output | 1 | High while normal operation is active |

## Verification
The bench builds the block with its default parameters: a 12-bit word, a 4-bit revision code of 1, the format selector at bit 8 and two frame copies. With these values, both frame lengths (256 and 320 bits per copy) and the hand-off to the daisy-chain input after 512 and 640 bits can be reached, all within a few thousand block cycles. The bench compares every bit of both long frames, including the zero run and the full signature tail. It also covers load sessions that are restarted or cut short by conversion control, and readback edges given before a load completes or during normal operation.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

  // Signature tail carried at the end of every readback copy
  localparam int unsigned    SIG_W       = 72;
  localparam logic [71:0]    SIG_LONG    = 72'h30F066012480F69055;
  localparam int unsigned    SIG_SHORT_W = 56;

  // Bits per frame copy for the two formats
  localparam int unsigned COPY_LEN_SHORT = 256;
  localparam int unsigned COPY_LEN_LONG  = 320;
  localparam int unsigned IDX_W          = $clog2(COPY_LEN_LONG);

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_LOAD   = 2'd1,
    ST_READ   = 2'd2
  } cfgState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startSess;
    logic takeBit;
    logic commit;
    logic shiftOut;
    logic goNormal;
  } dpCtl_t;

endpackage

// File: rtl/cfgrb_ctrl.sv
module cfgrb_ctrl
  import cfgrb_pkg::*;
#(
  parameter int unsigned CFG_W = 12
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   convIn,
  input  logic   rstStrobe,
  input  logic   cfgClk,
  input  logic   rdClk,
  output dpCtl_t ctl,
  output logic   normalMode
);

  localparam int unsigned CNT_W = $clog2(CFG_W + 1);

  logic convQ, strbQ, cfgClkQ, rdClkQ;
  logic convRise, strbRise, cfgFall, rdRise;
  cfgState_e state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convQ   <= 1'b0;
      strbQ   <= 1'b0;
      cfgClkQ <= 1'b0;
      rdClkQ  <= 1'b0;
    end else begin
      convQ   <= convIn;
      strbQ   <= rstStrobe;
      cfgClkQ <= cfgClk;
      rdClkQ  <= rdClk;
    end
  end

  assign convRise = convIn & ~convQ;
  assign strbRise = rstStrobe & ~strbQ;
  assign cfgFall  = ~cfgClk & cfgClkQ;
  assign rdRise   = rdClk & ~rdClkQ;

  always_comb begin
    ctl           = '0;
    ctl.startSess = strbRise && !convIn;
    ctl.goNormal  = !ctl.startSess && convRise && (state != ST_NORMAL);
    ctl.takeBit   = !ctl.startSess && !ctl.goNormal && (state == ST_LOAD)
                    && cfgFall && (32'(bitCnt) < CFG_W);
    ctl.commit    = ctl.takeBit && (32'(bitCnt) == CFG_W - 1);
    ctl.shiftOut  = !ctl.startSess && !ctl.goNormal && (state == ST_READ) && rdRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_NORMAL;
      bitCnt <= '0;
    end else if (ctl.startSess) begin
      state  <= ST_LOAD;
      bitCnt <= '0;
    end else if (ctl.goNormal) begin
      state  <= ST_NORMAL;
      bitCnt <= '0;
    end else if (ctl.commit) begin
      state  <= ST_READ;
      bitCnt <= '0;
    end else if (ctl.takeBit) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign normalMode = (state == ST_NORMAL);

  // R3
  load_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> (32'(bitCnt) < CFG_W));

  // R2
  session_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strbRise && !convIn) |=> (state == ST_LOAD) && (bitCnt == '0));

endmodule

// File: rtl/cfgrb_dp.sv
module cfgrb_dp
  import cfgrb_pkg::*;
#(
  parameter int unsigned       CFG_W   = 12,
  parameter int unsigned       REV_W   = 4,
  parameter logic [REV_W-1:0]  REV_ID  = 4'h1,
  parameter int unsigned       FMT_POS = 8,
  parameter int unsigned       COPIES  = 2,
  parameter logic [CFG_W-1:0]  CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             cfgBit,
  input  logic             chainIn,
  output logic [CFG_W-1:0] cfgWord,
  output logic             dout
);

  localparam int unsigned HDR_W = CFG_W + REV_W;
  localparam int unsigned CPY_W = $clog2(COPIES + 1);

  logic [CFG_W-2:0] shiftReg;
  logic [IDX_W-1:0] bitIdx;
  logic [CPY_W-1:0] copyCnt;
  logic             fmtLong;
  int unsigned      copyLen, tailW, tailStart, idxI;
  logic [HDR_W-1:0] hdr;
  logic             nextBit, inFrame, lastOfCopy;

  assign fmtLong    = cfgWord[FMT_POS];
  assign copyLen    = fmtLong ? COPY_LEN_LONG : COPY_LEN_SHORT;
  assign tailW      = fmtLong ? SIG_W : SIG_SHORT_W;
  assign tailStart  = copyLen - tailW;
  assign idxI       = 32'(bitIdx);
  assign hdr        = {cfgWord, REV_ID};
  assign inFrame    = 32'(copyCnt) < COPIES;
  assign lastOfCopy = (idxI == copyLen - 1);

  // Frame bit at the current position: header, zero run, or signature tail
  always_comb begin
    nextBit = 1'b0;
    if (idxI < HDR_W) begin
      nextBit = |(hdr & (HDR_W'(1) << (HDR_W - 1 - idxI)));
    end else if (idxI >= tailStart) begin
      nextBit = |(SIG_LONG & (SIG_W'(1) << (SIG_W - 1 - (idxI - tailStart))));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cfgWord  <= CFG_RST;
    end else begin
      if (ctl.startSess) begin
        shiftReg <= '0;
      end else if (ctl.takeBit) begin
        shiftReg <= {shiftReg[CFG_W-3:0], cfgBit};
      end
      if (ctl.commit) begin
        cfgWord <= {shiftReg, cfgBit};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      copyCnt <= '0;
      dout    <= 1'b0;
    end else if (ctl.startSess || ctl.goNormal) begin
      bitIdx  <= '0;
      copyCnt <= '0;
      dout    <= 1'b0;
    end else if (ctl.shiftOut) begin
      if (inFrame) begin
        dout <= nextBit;
        if (lastOfCopy) begin
          bitIdx  <= '0;
          copyCnt <= copyCnt + 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        dout <= chainIn;
      end
    end
  end

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(cfgWord));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shiftOut && !ctl.startSess && !ctl.goNormal)
      |=> ($stable(bitIdx) && $stable(copyCnt)));

  // R8
  copy_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(copyCnt) <= COPIES);

endmodule

// File: rtl/serial_cfg_reg.sv
module serial_cfg_reg
  import cfgrb_pkg::*;
#(
  parameter int unsigned       CFG_W   = 12,
  parameter int unsigned       REV_W   = 4,
  parameter logic [REV_W-1:0]  REV_ID  = 4'h1,
  parameter int unsigned       FMT_POS = 8,
  parameter int unsigned       COPIES  = 2,
  parameter logic [CFG_W-1:0]  CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convIn,
  input  logic             rstStrobe,
  input  logic             cfgDin,
  input  logic             cfgClk,
  input  logic             rdClk,
  input  logic             chainIn,
  output logic             dout,
  output logic [CFG_W-1:0] cfgWord,
  output logic             normalMode
);

  dpCtl_t ctl;

  cfgrb_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convIn    (convIn),
    .rstStrobe (rstStrobe),
    .cfgClk    (cfgClk),
    .rdClk     (rdClk),
    .ctl       (ctl),
    .normalMode(normalMode)
  );

  cfgrb_dp #(
    .CFG_W  (CFG_W),
    .REV_W  (REV_W),
    .REV_ID (REV_ID),
    .FMT_POS(FMT_POS),
    .COPIES (COPIES),
    .CFG_RST(CFG_RST)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cfgBit (cfgDin),
    .chainIn(chainIn),
    .cfgWord(cfgWord),
    .dout   (dout)
  );

  // R9
  normal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    normalMode |-> (dout == 1'b0));

  // R9
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(normalMode) |-> $past(convIn));

endmodule

// File: tb/tb_serial_cfg_reg.sv
`timescale 1ns/1ps
module tb_serial_cfg_reg;

  localparam time CYC = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convIn = 1'b0, rstStrobe = 1'b0, cfgDin = 1'b0, cfgClk = 1'b0;
  logic rdClk = 1'b0, chainIn = 1'b0;
  logic dout, normalMode;
  logic [11:0] cfgWord;

  int checks = 0;
  int fails  = 0;

  bit    expQ[$];
  string tagQ[$];
  logic  rdOld = 1'b0;

  always #(CYC/2) clk = ~clk;

  serial_cfg_reg dut (
    .clk(clk), .rstN(rstN), .convIn(convIn), .rstStrobe(rstStrobe),
    .cfgDin(cfgDin), .cfgClk(cfgClk), .rdClk(rdClk), .chainIn(chainIn),
    .dout(dout), .cfgWord(cfgWord), .normalMode(normalMode)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected frame bit k of the stream, from the requirements (R5, R6, R7)
  function automatic bit frameBit(logic [11:0] w, int k);
    logic [71:0] sig;
    logic [71:0] sh;
    logic [15:0] hdr;
    logic [15:0] hs;
    int len, tw, j;
    sig = 72'h30F066012480F69055;
    hdr = {w, 4'h1};
    len = w[8] ? 320 : 256;
    tw  = w[8] ? 72 : 56;
    j   = k % len;
    if (j < 16) begin
      hs = hdr >> (15 - j);
      return hs[0];
    end
    if (j < len - tw) return 1'b0;
    sh = sig >> (71 - (j - (len - tw)));
    return sh[0];
  endfunction

  task automatic strobeSession();
    rstStrobe = 1'b1; tick();
    rstStrobe = 1'b0; tick();
  endtask

  task automatic strobeConv();
    convIn = 1'b1; tick();
    convIn = 1'b0; tick();
  endtask

  task automatic sendBits(logic [11:0] w, int n);
    for (int i = 0; i < n; i++) begin
      cfgDin = w[11 - (i % 12)];
      cfgClk = 1'b1; tick();
      cfgClk = 1'b0; tick();
    end
  endtask

  // One readback edge, expected value queued for the monitor
  task automatic rdPulse(bit exp, string tag, logic chainVal);
    chainIn = chainVal;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdClk = 1'b1; tick();
    rdClk = 1'b0; tick();
  endtask

  // Driver: full two-copy frame plus chain bits
  task automatic readFrame(logic [11:0] w, int chainBits);
    int len;
    len = w[8] ? 320 : 256;
    for (int k = 0; k < 2 * len; k++) begin
      if ((k % len) < 16) rdPulse(frameBit(w, k), "R5", 1'b0);
      else if (w[8])      rdPulse(frameBit(w, k), "R7", 1'b1);
      else                rdPulse(frameBit(w, k), "R6", 1'b1);
    end
    for (int c = 0; c < chainBits; c++) begin
      rdPulse(((c % 3) != 1), "R8", ((c % 3) != 1));
    end
  endtask

  // Monitor: compares dout after each readback rising edge
  always @(posedge clk) begin
    logic rdNow;
    bit   e;
    string t;
    rdNow = rdClk;
    #1;
    if (rdNow && !rdOld) begin
      if (expQ.size() == 0) begin
        check("monitor underflow", 32'd1, 32'd0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {31'd0, dout}, {31'd0, e});
      end
    end
    rdOld = rdNow;
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CYC * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check("R1 word", 32'(cfgWord), 32'h000);
    check("R1 normal", 32'(normalMode), 32'd1);
    check("R1 dout", 32'(dout), 32'd0);

    // R9 normal mode ignores both serial clocks
    rdPulse(1'b0, "R9", 1'b1);
    rdPulse(1'b0, "R9", 1'b1);
    sendBits(12'hFFF, 12);
    check("R9 word untouched", 32'(cfgWord), 32'h000);

    // R2 strobe with conversion control high is ignored
    convIn = 1'b1; tick(); tick();
    strobeSession();
    check("R2 conv high", 32'(normalMode), 32'd1);
    convIn = 1'b0; tick();
    check("R2 conv fall", 32'(normalMode), 32'd1);
    strobeSession();
    check("R2 session", 32'(normalMode), 32'd0);

    // R10 readback before the load completes
    rdPulse(1'b0, "R10", 1'b1);
    rdPulse(1'b0, "R10", 1'b1);

    // R3 all-or-nothing load, short format
    sendBits(12'hA5C, 11);
    check("R3 partial", 32'(cfgWord), 32'h000);
    cfgDin = 1'b0; cfgClk = 1'b1; tick(); cfgClk = 1'b0; tick();
    check("R3 full", 32'(cfgWord), 32'hA5C);
    readFrame(12'hA5C, 5);

    // R4 restarted session keeps the old word
    strobeSession();
    sendBits(12'h3C7, 5);
    strobeSession();
    check("R4 restart", 32'(cfgWord), 32'hA5C);
    rdPulse(1'b0, "R10", 1'b1);

    // Long format load, extra bits ignored (R3)
    sendBits(12'h3C7, 12);
    check("R3 long word", 32'(cfgWord), 32'h3C7);
    sendBits(12'h000, 4);
    check("R3 extra bits", 32'(cfgWord), 32'h3C7);
    readFrame(12'h3C7, 4);

    // R4 and R9 conversion control cuts the session short
    strobeSession();
    sendBits(12'h0F0, 7);
    strobeConv();
    check("R9 normal", 32'(normalMode), 32'd1);
    check("R4 conv abort", 32'(cfgWord), 32'h3C7);
    rdPulse(1'b0, "R9", 1'b1);
    check("R9 dout quiet", 32'(dout), 32'd0);

    repeat (3) tick();
    check("queue drained", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule